// File: doc/BRIEF.md
# Boot parameter table checker

This block consumes a boot parameter table as a stream of 16-bit halfwords, beginning with the halfword at byte offset 0. The first halfword gives the table size in bytes, counting that halfword itself. The block keeps a running ones-complement sum (with end-around carry) over every halfword of the table, the stored checksum field included. After the final halfword it reports whether the table is well formed.

When the length is acceptable, the block also presents the header contents in decoded form. This covers the boot mode code and whether that code is recognised. It covers the port selection, including the value that selects every port. It covers the PLL request: the multiplier, pre-divider and post-divider factors, plus the action code turned into two flags, "configure if idle or bypassed" and "force bypass". Factor fields that hold zero are shown as one.

A controlling agent pulses `start_i` before each table and then supplies halfwords qualified by `hw_valid_i`. A single-cycle `done_o` pulse marks the moment the verdict and decoded fields become valid. They stay unchanged until the next start.

Top module: `boot_table_checker`

## Requirements
- R1: Halfword 0 carries the table size in bytes. For an accepted size N, the table ends after N/2 halfwords. `done_o` is high for exactly one cycle, in the cycle following the clock edge that accepted the last halfword.
- R2: Each accepted halfword, the checksum field (halfword 1) included, is added into a 16-bit ones-complement sum with end-around carry. When the stored checksum field is nonzero, the table passes only if the final sum is 0xFFFF. Otherwise `csum_err_o` is set and `table_ok_o` stays low.
- R3: A stored checksum field of 0x0000 turns off the sum check, and such a table with an acceptable length is reported as good.
- R4: The size is rejected if it is odd, below 12 or above MAX_LEN_BYTES. In that case `done_o` pulses in the cycle after the size halfword, with `len_err_o`=1, `table_ok_o`=0, `csum_err_o`=0, and every decoded output stays 0.
- R5: `boot_mode_o` shows halfword 2. `mode_unknown_o` is set unless the decimal value is one of 10, 20, 30, 40, 41, 42, 50, 60, 70, 80, 81, 100, 110.
- R6: `port_num_o` shows halfword 3. `all_ports_o` is set exactly when that halfword is 0xFFFF.
- R7: Halfword 4 is bits 31:16 and halfword 5 is bits 15:0 of the PLL word. Bits 29:16 hold the multiplier, bits 15:8 the pre-divider and bits 7:0 the post-divider. Each factor is output as stored, except that a stored 0 is output as 1.
- R8: Bits 31:30 of the PLL word select the action. 00 sets neither flag, 01 and 10 set `pll_cond_o`, and 11 sets `pll_bypass_o`. A boot mode of 100 clears both flags.
- R9: `start_i` clears every output and all accumulated state on the following edge, and it opens a new table. A halfword presented in the same cycle as `start_i` is discarded.
- R10: Once the verdict is out, later halfwords are ignored, and all outputs keep their values until the next `start_i`.
- R11: After reset all outputs are 0, and halfwords are ignored until the first `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Clear state and begin a new table |
| hw_valid_i | input | 1 | `hw_data_i` holds the next halfword |
| hw_data_i | input | 16 | Table halfword |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| table_ok_o | output | 1 | Size and checksum both acceptable |
| csum_err_o | output | 1 | Size acceptable, checksum failed |
| len_err_o | output | 1 | Size field rejected |
| mode_unknown_o | output | 1 | Boot mode code not recognised |
| boot_mode_o | output | 16 | Boot mode code |
| port_num_o | output | 16 | Port selection |
| all_ports_o | output | 1 | Port selection is 0xFFFF |
| pll_cond_o | output | 1 | Configure PLL only when idle or bypassed |
| pll_bypass_o | output | 1 | Disable PLL and bypass it |
| pll_mult_o | output | 14 | Multiplier factor, zero shown as one |
| pll_prediv_o | output | 8 | Pre-divider factor, zero shown as one |
| pll_postdiv_o | output | 8 | Post-divider factor, zero shown as one |

## Verification
The bench instantiates the block with MAX_LEN_BYTES set to 32. This lets random tables span the whole accepted size range, from 12 to 32 bytes. It also makes the first too-large size, 34, reachable with a single halfword. The same setting means the extreme case is exercised on both sides: the largest table is accepted, and a size just above it is rejected along with odd and short sizes. The random tables mix recognised and unrecognised mode codes, zero factors, disabled checksums and corrupted halfwords.

// File: rtl/boot_tbl_pkg.sv
package boot_tbl_pkg;

   localparam int unsigned HW_W          = 16;
   localparam int unsigned MULT_W        = 14;
   localparam int unsigned DIV_W         = 8;
   localparam int unsigned NUM_FIELDS    = 6;
   localparam int unsigned MIN_LEN_BYTES = 12;

   typedef logic [HW_W-1:0] hword_t;

   // halfword index of each header field (stream order is behaviour)
   localparam int unsigned FI_LEN  = 0;
   localparam int unsigned FI_CSUM = 1;
   localparam int unsigned FI_MODE = 2;
   localparam int unsigned FI_PORT = 3;
   localparam int unsigned FI_PLLH = 4;
   localparam int unsigned FI_PLLL = 5;

   localparam hword_t MODE_SLEEP = 16'd100;
   localparam hword_t PORT_ALL   = 16'hFFFF;

   function automatic logic mode_known(input hword_t m);
      case (m)
         16'd10, 16'd20, 16'd30, 16'd40, 16'd41, 16'd42, 16'd50,
         16'd60, 16'd70, 16'd80, 16'd81, 16'd100, 16'd110: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bt_csum_acc.sv
module bt_csum_acc #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         add_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] sum_o,
   output logic [W-1:0] next_o
);

   logic [W:0]   raw;
   logic [W-1:0] sum_q;

   // end-around carry: the carry out folds back into bit 0
   always_comb begin
      raw    = {1'b0, sum_q} + {1'b0, data_i};
      next_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sum_q <= '0;
      else if (clr_i) sum_q <= '0;
      else if (add_i) sum_q <= next_o;
   end

   assign sum_o = sum_q;

endmodule

// File: rtl/bt_field_capture.sv
module bt_field_capture #(
   parameter int unsigned NF    = 6,
   parameter int unsigned IDX_W = 4,
   parameter int unsigned W     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr_i,
   input  logic                 we_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic [W-1:0]         data_i,
   output logic [NF-1:0][W-1:0] fields_o
);

   generate
      if ((1 << IDX_W) < NF) begin : g_bad_idx
         $error("bt_field_capture: IDX_W too narrow for NF");
      end
      for (genvar f = 0; f < NF; f++) begin : g_fld
         logic [W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                q <= '0;
            else if (clr_i)                            q <= '0;
            else if (we_i && idx_i == IDX_W'(f))       q <= data_i;
         end
         assign fields_o[f] = q;
      end
   endgenerate

endmodule

// File: rtl/bt_cfg_decode.sv
module bt_cfg_decode
   import boot_tbl_pkg::*;
(
   input  logic              show_i,
   input  hword_t            mode_i,
   input  hword_t            port_i,
   input  hword_t            pll_hi_i,
   input  hword_t            pll_lo_i,
   output logic              mode_unknown_o,
   output hword_t            mode_o,
   output hword_t            port_o,
   output logic              all_ports_o,
   output logic              pll_cond_o,
   output logic              pll_bypass_o,
   output logic [MULT_W-1:0] mult_o,
   output logic [DIV_W-1:0]  prediv_o,
   output logic [DIV_W-1:0]  postdiv_o
);

   logic [1:0]        ctl;
   logic [MULT_W-1:0] mult_raw;
   logic [DIV_W-1:0]  pre_raw, post_raw;
   logic              sleep;

   assign ctl      = pll_hi_i[HW_W-1 -: 2];
   assign mult_raw = pll_hi_i[MULT_W-1:0];
   assign pre_raw  = pll_lo_i[HW_W-1 -: DIV_W];
   assign post_raw = pll_lo_i[DIV_W-1:0];
   assign sleep    = (mode_i == MODE_SLEEP);

   always_comb begin
      mode_unknown_o = 1'b0;
      mode_o         = '0;
      port_o         = '0;
      all_ports_o    = 1'b0;
      pll_cond_o     = 1'b0;
      pll_bypass_o   = 1'b0;
      mult_o         = '0;
      prediv_o       = '0;
      postdiv_o      = '0;
      if (show_i) begin
         mode_unknown_o = ~mode_known(mode_i);
         mode_o         = mode_i;
         port_o         = port_i;
         all_ports_o    = (port_i == PORT_ALL);
         pll_cond_o     = ~sleep & (ctl == 2'b01 || ctl == 2'b10);
         pll_bypass_o   = ~sleep & (ctl == 2'b11);
         mult_o         = (mult_raw == '0) ? MULT_W'(1) : mult_raw;
         prediv_o       = (pre_raw  == '0) ? DIV_W'(1)  : pre_raw;
         postdiv_o      = (post_raw == '0) ? DIV_W'(1)  : post_raw;
      end
   end

endmodule

// File: rtl/boot_table_checker.sv
module boot_table_checker
   import boot_tbl_pkg::*;
#(
   parameter int unsigned MAX_LEN_BYTES = 128
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               hw_valid_i,
   input  logic [15:0]        hw_data_i,
   output logic               done_o,
   output logic               table_ok_o,
   output logic               csum_err_o,
   output logic               len_err_o,
   output logic               mode_unknown_o,
   output logic [15:0]        boot_mode_o,
   output logic [15:0]        port_num_o,
   output logic               all_ports_o,
   output logic               pll_cond_o,
   output logic               pll_bypass_o,
   output logic [13:0]        pll_mult_o,
   output logic [7:0]         pll_prediv_o,
   output logic [7:0]         pll_postdiv_o
);

   localparam int unsigned HALF_MAX = MAX_LEN_BYTES / 2;
   localparam int unsigned IDX_W    = $clog2(HALF_MAX + 1);

   generate
      if (MAX_LEN_BYTES < MIN_LEN_BYTES) begin : g_max_small
         $error("boot_table_checker: MAX_LEN_BYTES below header size");
      end
      if (MAX_LEN_BYTES % 2 != 0) begin : g_max_odd
         $error("boot_table_checker: MAX_LEN_BYTES must be even");
      end
      if (MAX_LEN_BYTES > 65534) begin : g_max_big
         $error("boot_table_checker: MAX_LEN_BYTES exceeds 16-bit size field");
      end
   endgenerate

   logic                               active_q, done_q, have_q;
   logic                               ok_q, cerr_q, lerr_q;
   logic [IDX_W-1:0]                   idx_q;
   logic [NUM_FIELDS-1:0][HW_W-1:0]    fld;
   hword_t                             sum_q, sum_next;
   logic                               accept, first_hw, len_bad, at_end;
   logic                               last_hw, sum_pass, show;
   hword_t                             idx_plus;

   assign accept   = active_q & hw_valid_i & ~start_i;
   assign first_hw = (idx_q == '0);
   assign len_bad  = hw_data_i[0]
                   | (hw_data_i < HW_W'(MIN_LEN_BYTES))
                   | ({16'h0, hw_data_i} > 32'(MAX_LEN_BYTES));
   assign idx_plus = HW_W'(idx_q) + HW_W'(1);
   assign at_end   = (idx_plus == {1'b0, fld[FI_LEN][HW_W-1:1]});
   assign last_hw  = accept & (first_hw ? len_bad : at_end);
   assign sum_pass = (fld[FI_CSUM] == '0) | (sum_next == '1);

   bt_csum_acc #(.W(HW_W)) i_csum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (start_i),
      .add_i  (accept),
      .data_i (hw_data_i),
      .sum_o  (sum_q),
      .next_o (sum_next)
   );

   bt_field_capture #(.NF(NUM_FIELDS), .IDX_W(IDX_W), .W(HW_W)) i_fields (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (start_i),
      .we_i     (accept),
      .idx_i    (idx_q),
      .data_i   (hw_data_i),
      .fields_o (fld)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         done_q   <= 1'b0;
         have_q   <= 1'b0;
         ok_q     <= 1'b0;
         cerr_q   <= 1'b0;
         lerr_q   <= 1'b0;
      end else if (start_i) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         done_q   <= 1'b0;
         have_q   <= 1'b0;
         ok_q     <= 1'b0;
         cerr_q   <= 1'b0;
         lerr_q   <= 1'b0;
      end else begin
         done_q <= last_hw;
         if (accept && !last_hw) idx_q <= idx_q + IDX_W'(1);
         if (last_hw) begin
            active_q <= 1'b0;
            have_q   <= 1'b1;
            lerr_q   <= first_hw;
            ok_q     <= ~first_hw & sum_pass;
            cerr_q   <= ~first_hw & ~sum_pass;
         end
      end
   end

   assign show = have_q & ~lerr_q;

   bt_cfg_decode i_decode (
      .show_i         (show),
      .mode_i         (fld[FI_MODE]),
      .port_i         (fld[FI_PORT]),
      .pll_hi_i       (fld[FI_PLLH]),
      .pll_lo_i       (fld[FI_PLLL]),
      .mode_unknown_o (mode_unknown_o),
      .mode_o         (boot_mode_o),
      .port_o         (port_num_o),
      .all_ports_o    (all_ports_o),
      .pll_cond_o     (pll_cond_o),
      .pll_bypass_o   (pll_bypass_o),
      .mult_o         (pll_mult_o),
      .prediv_o       (pll_prediv_o),
      .postdiv_o      (pll_postdiv_o)
   );

   assign done_o     = done_q;
   assign table_ok_o = ok_q;
   assign csum_err_o = cerr_q;
   assign len_err_o  = lerr_q;

   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R1
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(idx_q) <= HALF_MAX);

   // R2
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(table_ok_o && (csum_err_o || len_err_o)));

   // R4
   len_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      len_err_o |-> (boot_mode_o == '0 && !pll_cond_o && !pll_bypass_o && pll_mult_o == '0));

   // R7
   factor_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !len_err_o) |-> (pll_mult_o != '0 && pll_prediv_o != '0 && pll_postdiv_o != '0));

   // R8
   sleep_no_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_mode_o == MODE_SLEEP) |-> (!pll_cond_o && !pll_bypass_o));

   // R9
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && !table_ok_o && !len_err_o && !csum_err_o));

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !start_i) |=> ($stable(table_ok_o) && $stable(boot_mode_o) && $stable(pll_mult_o)));

endmodule

// File: tb/test_boot_table_checker.sv
`timescale 1ns/1ps
module test_boot_table_checker;

   localparam int unsigned MAXB = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        hw_valid_i = 1'b0;
   logic [15:0] hw_data_i = '0;
   logic        done_o, table_ok_o, csum_err_o, len_err_o, mode_unknown_o;
   logic [15:0] boot_mode_o, port_num_o;
   logic        all_ports_o, pll_cond_o, pll_bypass_o;
   logic [13:0] pll_mult_o;
   logic [7:0]  pll_prediv_o, pll_postdiv_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] tbl [0:31];

   always #4 clk = ~clk;

   boot_table_checker #(.MAX_LEN_BYTES(MAXB)) i_boot_table_checker (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .hw_valid_i(hw_valid_i),
      .hw_data_i(hw_data_i), .done_o(done_o), .table_ok_o(table_ok_o),
      .csum_err_o(csum_err_o), .len_err_o(len_err_o), .mode_unknown_o(mode_unknown_o),
      .boot_mode_o(boot_mode_o), .port_num_o(port_num_o), .all_ports_o(all_ports_o),
      .pll_cond_o(pll_cond_o), .pll_bypass_o(pll_bypass_o), .pll_mult_o(pll_mult_o),
      .pll_prediv_o(pll_prediv_o), .pll_postdiv_o(pll_postdiv_o)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] ocsum(input int n);
      logic [16:0] s = '0;
      for (int i = 0; i < n; i++) begin
         s = {1'b0, s[15:0]} + {1'b0, tbl[i]};
         s = {1'b0, s[15:0] + {15'h0, s[16]}};
      end
      return s[15:0];
   endfunction

   function automatic logic known(input logic [15:0] m);
      int v = int'(m);
      return v == 10 || v == 20 || v == 30 || v == 40 || v == 41 || v == 42 ||
             v == 50 || v == 60 || v == 70 || v == 80 || v == 81 || v == 100 || v == 110;
   endfunction

   function automatic logic len_bad(input logic [15:0] l);
      return l[0] || l < 16'd12 || l > 16'(MAXB);
   endfunction

   task automatic check_all_zero(input string req);
      chk(req, "done", {31'h0, done_o}, 0);
      chk(req, "ok", {31'h0, table_ok_o}, 0);
      chk(req, "flags", {27'h0, csum_err_o, len_err_o, mode_unknown_o, pll_cond_o, pll_bypass_o}, 0);
      chk(req, "mode/port", {boot_mode_o, port_num_o}, 0);
      chk(req, "factors", {2'b0, pll_mult_o, pll_prediv_o, pll_postdiv_o}, 0);
   endtask

   // sampled one negedge after the edge that took the last halfword
   task automatic check_result(input string req);
      logic        lb = len_bad(tbl[0]);
      logic        pass, sl;
      logic [1:0]  ctl;
      logic [13:0] m;
      logic [7:0]  pr, po;
      chk("R1", "done pulse", {31'h0, done_o}, 1);
      if (lb) begin
         chk("R4", "len_err", {31'h0, len_err_o}, 1);
         chk("R4", "ok/cerr", {30'h0, table_ok_o, csum_err_o}, 0);
         chk("R4", "decoded", {boot_mode_o, port_num_o}, 0);
         chk("R4", "pll", {pll_cond_o, pll_bypass_o, pll_mult_o, pll_prediv_o, pll_postdiv_o}, 0);
      end else begin
         pass = (tbl[1] == 16'h0) || (ocsum(int'(tbl[0]) / 2) == 16'hFFFF);
         sl   = (tbl[2] == 16'd100);
         ctl  = tbl[4][15:14];
         m    = (tbl[4][13:0] == 0) ? 14'd1 : tbl[4][13:0];
         pr   = (tbl[5][15:8] == 0) ? 8'd1 : tbl[5][15:8];
         po   = (tbl[5][7:0] == 0) ? 8'd1 : tbl[5][7:0];
         chk(req, "R2/R3 ok,cerr,lerr", {29'h0, table_ok_o, csum_err_o, len_err_o}, {29'h0, pass, !pass, 1'b0});
         chk("R5", "mode", {15'h0, mode_unknown_o, boot_mode_o}, {15'h0, !known(tbl[2]), tbl[2]});
         chk("R6", "port", {15'h0, all_ports_o, port_num_o}, {15'h0, tbl[3] == 16'hFFFF, tbl[3]});
         chk("R7", "factors", {2'b0, pll_mult_o, pll_prediv_o, pll_postdiv_o}, {2'b0, m, pr, po});
         chk("R8", "pll action", {30'h0, pll_cond_o, pll_bypass_o},
             {30'h0, !sl && (ctl == 2'b01 || ctl == 2'b10), !sl && ctl == 2'b11});
      end
      @(negedge clk);
      chk("R1", "done low after pulse", {31'h0, done_o}, 0);
   endtask

   task automatic do_start();
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      check_all_zero("R9");
   endtask

   task automatic send(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); hw_valid_i = 1'b1; hw_data_i = tbl[i];
      end
      @(negedge clk); hw_valid_i = 1'b0; hw_data_i = $urandom();
   endtask

   task automatic run_table(input string req);
      int n = len_bad(tbl[0]) ? 1 : int'(tbl[0]) / 2;
      do_start();
      send(n);
      check_result(req);
   endtask

   task automatic build(input int len, input logic [15:0] mode, input logic [1:0] ctl,
                        input bit zero_cs, input bit corrupt);
      for (int i = 0; i < 32; i++) tbl[i] = $urandom();
      tbl[0] = 16'(len);
      tbl[1] = 16'h0;
      tbl[2] = mode;
      if ($urandom_range(0, 3) == 0) tbl[3] = 16'hFFFF;
      tbl[4][15:14] = ctl;
      if ($urandom_range(0, 3) == 0) tbl[4][13:0] = '0;
      if ($urandom_range(0, 3) == 0) tbl[5][15:8] = '0;
      if ($urandom_range(0, 3) == 0) tbl[5][7:0] = '0;
      if (!zero_cs && len >= 12 && len <= 32) tbl[1] = ~ocsum(len / 2);
      if (corrupt && len >= 12 && len <= 32) tbl[len / 2 - 1] ^= 16'h0100;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] modes [0:12];
      int          bad_lens [0:4];
      logic [15:0] held;
      void'($urandom(32'd2024));
      modes = '{16'd10, 16'd20, 16'd30, 16'd40, 16'd41, 16'd42, 16'd50,
                16'd60, 16'd70, 16'd80, 16'd81, 16'd100, 16'd110};
      bad_lens = '{10, 13, 34, 0, 31};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all_zero("R11");

      // R11: halfwords before the first start are ignored
      build(12, 16'd50, 2'b01, 0, 0);
      send(6);
      check_all_zero("R11");

      // R1 R2: minimum and maximum good tables
      build(12, 16'd10, 2'b01, 0, 0);
      run_table("R2");
      build(32, 16'd110, 2'b10, 0, 0);
      run_table("R1");

      // R3: checksum disabled, sum deliberately wrong
      build(20, 16'd30, 2'b11, 1, 1);
      tbl[1] = 16'h0;
      run_table("R3");

      // R2: corrupted table
      build(16, 16'd40, 2'b00, 0, 1);
      run_table("R2");

      // R4: rejected sizes, then R10 ignores further halfwords
      foreach (bad_lens[k]) begin
         build(bad_lens[k], 16'd20, 2'b01, 0, 0);
         run_table("R4");
      end
      send(5);
      chk("R10", "no done after verdict", {31'h0, done_o}, 0);
      chk("R10", "len_err held", {31'h0, len_err_o}, 1);

      // R8: sleep mode suppresses bypass
      build(14, 16'd100, 2'b11, 0, 0);
      run_table("R8");
      build(14, 16'd60, 2'b11, 0, 0);
      run_table("R8");

      // R5 R6 R7: unknown mode, all ports, zero factors
      build(18, 16'd99, 2'b10, 0, 0);
      tbl[3] = 16'hFFFF; tbl[4][13:0] = '0; tbl[5] = 16'h0000;
      tbl[1] = 16'h0; tbl[1] = ~ocsum(9);
      run_table("R7");
      held = boot_mode_o;
      // R10: extra halfwords after verdict change nothing
      send(3);
      chk("R10", "mode held", {16'h0, boot_mode_o}, {16'h0, held});
      chk("R10", "mult held", {18'h0, pll_mult_o}, 32'd1);

      // R9: start mid-table, then start together with a halfword
      build(24, 16'd70, 2'b01, 0, 0);
      do_start();
      send(3);
      do_start();
      @(negedge clk); start_i = 1'b1; hw_valid_i = 1'b1; hw_data_i = tbl[0];
      @(negedge clk); start_i = 1'b0; hw_valid_i = 1'b0;
      send(12);
      check_result("R9");

      // random tables
      for (int t = 0; t < 80; t++) begin
         int len;
         logic [15:0] md;
         if ($urandom_range(0, 7) == 0) len = bad_lens[$urandom_range(0, 4)];
         else len = 2 * $urandom_range(6, 16);
         md = ($urandom_range(0, 9) < 7) ? modes[$urandom_range(0, 12)] : 16'($urandom_range(0, 200));
         build(len, md, 2'($urandom_range(0, 3)), $urandom_range(0, 5) == 0, $urandom_range(0, 3) == 0);
         run_table("R2");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule